// File: doc/BRIEF.md
# CKE Power-Down Controller

This block owns the clock-enable line of a double-data-rate SDRAM on the controller side. It accepts a power-down request level from the power manager. It watches busy levels and completion pulses from the read and write datapaths, and it takes an all-banks-idle level from the bank tracker. It lowers clock enable only when no access is in flight. It tells the rest of the controller whether the device sits in precharge power-down or active power-down. It pulls the device out again before the refresh window runs out.

A read counts as finished a programmable number of cycles after its completion pulse, which covers the postamble. A write counts as finished only after the write-recovery time has run. A request that arrives while an access is outstanding is latched and honoured once the access drains.

On every exit the block raises clock enable together with a forced NOP for exactly one cycle, then lets the command scheduler issue again. The control is a three-state machine:
- AWAKE: clock enable high, commands allowed.
- POWERED_DOWN: clock enable low.
- EXIT_NOP: clock enable high, NOP forced.

The transitions are these:
- AWAKE to POWERED_DOWN, when the request is present or latched and the access guard reports quiet.
- POWERED_DOWN to EXIT_NOP, when the request drops or the window timer expires; expiry takes precedence.
- EXIT_NOP to AWAKE, always after one cycle.

Top module: `cke_pd_ctrl`

## Requirements
- R1: While and right after reset, cke=1, mode=2'b00, force_nop=0, cmd_allowed=1 and refresh_due=0.
- R2: In AWAKE with pd_req high and no access activity sampled at an edge, cke is 0 and cmd_allowed is 0 from that edge on.
- R3: While rd_busy or wr_busy is high, cke stays 1. A pd_req seen during that time, even for one cycle, is latched and causes entry once the access completes.
- R4: After rd_done is sampled at edge e (busy low from then on), cke stays 1 through edge e+RD_POST. With a request pending, it goes 0 at edge e+RD_POST+1.
- R5: After wr_done is sampled at edge e, cke stays 1 through edge e+T_WR. With a request pending, it goes 0 at edge e+T_WR+1.
- R6: mode is 2'b01 (precharge power-down) if banks_idle was 1 at the entry edge, and 2'b10 (active power-down) if it was 0. banks_idle changes during power-down do not change mode. mode is 2'b00 whenever cke is 1.
- R7: pd_req sampled low in POWERED_DOWN gives one cycle with cke=1, force_nop=1 and cmd_allowed=0. The next cycle has force_nop=0 and cmd_allowed=1.
- R8: cke stays low for at most MAX_PD consecutive cycles. The forced exit after MAX_PD cycles occurs even with pd_req high, and refresh_due is 1 only in that exit NOP cycle.
- R9: After a forced exit, pd_req is ignored until it has been sampled low once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pd_req | input | 1 | Power-down request level |
| rd_busy | input | 1 | A read access is outstanding |
| rd_done | input | 1 | One-cycle pulse: read data burst finished |
| wr_busy | input | 1 | A write access is outstanding |
| wr_done | input | 1 | One-cycle pulse: write data burst finished |
| banks_idle | input | 1 | All banks precharged |
| cke | output | 1 | Clock enable to the device |
| mode | output | 2 | 00 awake, 01 precharge power-down, 10 active power-down |
| force_nop | output | 1 | Scheduler must issue NOP this cycle |
| cmd_allowed | output | 1 | Scheduler may issue real commands |
| refresh_due | output | 1 | Exit was forced by the refresh window |

## Verification
Every output is a function of the state register, so each result is due one edge after the stimulus that causes it. The entry after a completion pulse is due exactly RD_POST+1 or T_WR+1 edges after the pulse edge. The forced exit is due MAX_PD edges after entry. The bench drives inputs and samples all five outputs one time unit after each rising edge, and it counts edges explicitly before every check. The read and write drain windows are swept over several busy lengths with a small configuration, so the exact entry edge is confirmed against the arithmetic from the parameters.

// File: rtl/cke_pd_pkg.sv
package cke_pd_pkg;

    typedef enum logic [1:0] {
        ST_AWAKE    = 2'd0,
        ST_DOWN     = 2'd1,
        ST_EXIT_NOP = 2'd2
    } pd_state_t;

    localparam logic [1:0] MODE_AWAKE  = 2'b00;
    localparam logic [1:0] MODE_PRE_PD = 2'b01;
    localparam logic [1:0] MODE_ACT_PD = 2'b10;

endpackage

// File: rtl/pd_drain_counter.sv
module pd_drain_counter #(
    parameter int DLY = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic busy,
    input  logic done,
    output logic idle
);
    localparam int CW = (DLY < 1) ? 1 : $clog2(DLY + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (done) begin
            cnt_q <= CW'(DLY);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign idle = (cnt_q == '0) && !busy && !done;
endmodule

// File: rtl/pd_access_guard.sv
module pd_access_guard #(
    parameter int RD_POST = 2,
    parameter int T_WR    = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_busy,
    input  logic rd_done,
    input  logic wr_busy,
    input  logic wr_done,
    output logic quiet
);
    localparam int NCH = 2;

    logic [NCH-1:0] busy_v, done_v, idle_v;

    assign busy_v = {wr_busy, rd_busy};
    assign done_v = {wr_done, rd_done};

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        localparam int CH_DLY = (ch == 0) ? RD_POST : T_WR;
        pd_drain_counter #(.DLY(CH_DLY)) u_drain (
            .clk  (clk),
            .rst_n(rst_n),
            .busy (busy_v[ch]),
            .done (done_v[ch]),
            .idle (idle_v[ch])
        );
    end

    assign quiet = &idle_v;
endmodule

// File: rtl/pd_window_timer.sv
module pd_window_timer #(
    parameter int MAX_PD = 7800
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_pd,
    output logic expire
);
    localparam int CW = (MAX_PD < 2) ? 1 : $clog2(MAX_PD);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !in_pd) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expire = in_pd && (cnt_q == CW'(MAX_PD - 1));
endmodule

// File: rtl/pd_fsm.sv
module pd_fsm
    import cke_pd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pd_req,
    input  logic       quiet,
    input  logic       banks_idle,
    input  logic       expire,
    output logic       in_pd,
    output logic       cke,
    output logic [1:0] mode,
    output logic       force_nop,
    output logic       cmd_allowed,
    output logic       refresh_due
);
    pd_state_t  state_q, state_d;
    logic [1:0] mode_q, mode_d;
    logic       pend_q, pend_d;
    logic       hold_q, hold_d;
    logic       rdue_q, rdue_d;
    logic       req_eff;

    assign req_eff = (pd_req || pend_q) && !hold_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_AWAKE;
            mode_q  <= MODE_PRE_PD;
            pend_q  <= 1'b0;
            hold_q  <= 1'b0;
            rdue_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            mode_q  <= mode_d;
            pend_q  <= pend_d;
            hold_q  <= hold_d;
            rdue_q  <= rdue_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        mode_d  = mode_q;
        pend_d  = pend_q;
        hold_d  = hold_q && pd_req;
        rdue_d  = 1'b0;
        unique case (state_q)
            ST_AWAKE: begin
                if (req_eff && quiet) begin
                    state_d = ST_DOWN;
                    mode_d  = banks_idle ? MODE_PRE_PD : MODE_ACT_PD;
                    pend_d  = 1'b0;
                end else if (pd_req && !hold_q) begin
                    pend_d  = 1'b1;
                end
            end
            ST_DOWN: begin
                hold_d = hold_q;
                if (expire) begin
                    state_d = ST_EXIT_NOP;
                    rdue_d  = 1'b1;
                    hold_d  = 1'b1;
                end else if (!pd_req) begin
                    state_d = ST_EXIT_NOP;
                end
            end
            ST_EXIT_NOP: begin
                state_d = ST_AWAKE;
            end
            default: begin
                state_d = ST_AWAKE;
            end
        endcase
    end

    // outputs
    always_comb begin
        in_pd       = 1'b0;
        cke         = 1'b1;
        mode        = MODE_AWAKE;
        force_nop   = 1'b0;
        cmd_allowed = 1'b0;
        refresh_due = 1'b0;
        unique case (state_q)
            ST_AWAKE: begin
                cmd_allowed = 1'b1;
            end
            ST_DOWN: begin
                in_pd = 1'b1;
                cke   = 1'b0;
                mode  = mode_q;
            end
            ST_EXIT_NOP: begin
                force_nop   = 1'b1;
                refresh_due = rdue_q;
            end
            default: begin
                cmd_allowed = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/cke_pd_ctrl.sv
module cke_pd_ctrl #(
    parameter int RD_POST = 2,
    parameter int T_WR    = 4,
    parameter int MAX_PD  = 7800
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pd_req,
    input  logic       rd_busy,
    input  logic       rd_done,
    input  logic       wr_busy,
    input  logic       wr_done,
    input  logic       banks_idle,
    output logic       cke,
    output logic [1:0] mode,
    output logic       force_nop,
    output logic       cmd_allowed,
    output logic       refresh_due
);
    logic quiet;
    logic in_pd;
    logic expire;

    pd_access_guard #(.RD_POST(RD_POST), .T_WR(T_WR)) u_guard (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_busy(rd_busy),
        .rd_done(rd_done),
        .wr_busy(wr_busy),
        .wr_done(wr_done),
        .quiet  (quiet)
    );

    pd_window_timer #(.MAX_PD(MAX_PD)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .in_pd (in_pd),
        .expire(expire)
    );

    pd_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .pd_req     (pd_req),
        .quiet      (quiet),
        .banks_idle (banks_idle),
        .expire     (expire),
        .in_pd      (in_pd),
        .cke        (cke),
        .mode       (mode),
        .force_nop  (force_nop),
        .cmd_allowed(cmd_allowed),
        .refresh_due(refresh_due)
    );
endmodule

// File: rtl/cke_pd_checker.sv
module cke_pd_checker #(
    parameter int MAX_PD = 7800
) (
    input logic       clk,
    input logic       rst_n,
    input logic       rd_busy,
    input logic       rd_done,
    input logic       wr_busy,
    input logic       wr_done,
    input logic       cke,
    input logic [1:0] mode,
    input logic       force_nop,
    input logic       cmd_allowed,
    input logic       refresh_due
);
    localparam int RW = $clog2(MAX_PD + 2);

    logic [RW-1:0] low_run_q;

    always_ff @(posedge clk) begin
        if (!rst_n || cke) begin
            low_run_q <= '0;
        end else if (low_run_q <= RW'(MAX_PD)) begin
            low_run_q <= low_run_q + 1'b1;
        end
    end

    a_r3_busy_keeps_cke: assert property (@(posedge clk) disable iff (!rst_n)
        (cke && (rd_busy || wr_busy || rd_done || wr_done)) |=> cke);

    a_r2_no_cmd_when_down: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |-> !cmd_allowed && !force_nop);

    a_r6_mode_zero_awake: assert property (@(posedge clk) disable iff (!rst_n)
        cke |-> (mode == 2'b00));

    a_r6_mode_valid_down: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |-> (mode == 2'b01 || mode == 2'b10));

    a_r6_mode_stable_down: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke && $past(!cke)) |-> $stable(mode));

    a_r7_exit_with_nop: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke) |-> force_nop && !cmd_allowed);

    a_r7_nop_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        force_nop |=> cke && cmd_allowed && !force_nop);

    a_r8_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |-> (low_run_q < RW'(MAX_PD)));

    a_r8_refresh_in_nop: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_due |-> force_nop && $past(!cke));
endmodule

bind cke_pd_ctrl cke_pd_checker #(.MAX_PD(MAX_PD)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_busy    (rd_busy),
    .rd_done    (rd_done),
    .wr_busy    (wr_busy),
    .wr_done    (wr_done),
    .cke        (cke),
    .mode       (mode),
    .force_nop  (force_nop),
    .cmd_allowed(cmd_allowed),
    .refresh_due(refresh_due)
);

// File: tb/tb_cke_pd_ctrl.sv
module tb_cke_pd_ctrl;
    localparam int RD_POST = 2;
    localparam int T_WR    = 3;
    localparam int MAX_PD  = 8;

    // packed as {cke, mode, force_nop, cmd_allowed, refresh_due}
    localparam logic [5:0] O_AWAKE = 6'b100010;
    localparam logic [5:0] O_NOP   = 6'b100100;
    localparam logic [5:0] O_NOPRF = 6'b100101;
    localparam logic [5:0] O_PRE   = 6'b001000;
    localparam logic [5:0] O_ACT   = 6'b010000;

    logic       clk = 1'b0;
    logic       rst_n, pd_req, rd_busy, rd_done, wr_busy, wr_done, banks_idle;
    logic       cke, force_nop, cmd_allowed, refresh_due;
    logic [1:0] mode;
    int         checks = 0;
    int         errors = 0;
    bit         finished = 1'b0;

    always #2 clk = ~clk;

    cke_pd_ctrl #(.RD_POST(RD_POST), .T_WR(T_WR), .MAX_PD(MAX_PD)) dut (
        .clk(clk), .rst_n(rst_n), .pd_req(pd_req),
        .rd_busy(rd_busy), .rd_done(rd_done),
        .wr_busy(wr_busy), .wr_done(wr_done),
        .banks_idle(banks_idle),
        .cke(cke), .mode(mode), .force_nop(force_nop),
        .cmd_allowed(cmd_allowed), .refresh_due(refresh_due)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic expect_out(input string req, input logic [5:0] exp);
        logic [5:0] act;
        act = {cke, mode, force_nop, cmd_allowed, refresh_due};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; pd_req = 1'b0; rd_busy = 1'b0; rd_done = 1'b0;
        wr_busy = 1'b0; wr_done = 1'b0; banks_idle = 1'b1;
        repeat (3) step();
        expect_out("R1 in reset", O_AWAKE);
        rst_n = 1'b1;
        step();
        expect_out("R1 after reset", O_AWAKE);

        // R2 + R6: precharge power-down entry, hold, normal exit
        pd_req = 1'b1;
        step();
        expect_out("R2 entry", O_PRE);
        repeat (3) begin
            step();
            expect_out("R2 stay down", O_PRE);
        end
        pd_req = 1'b0;
        step();
        expect_out("R7 exit nop", O_NOP);
        step();
        expect_out("R7 commands again", O_AWAKE);

        // R6: active power-down, banks_idle change ignored
        banks_idle = 1'b0;
        pd_req = 1'b1;
        step();
        expect_out("R6 active entry", O_ACT);
        banks_idle = 1'b1;
        step();
        expect_out("R6 mode held", O_ACT);
        pd_req = 1'b0;
        step();
        expect_out("R6 mode zero on exit", O_NOP);
        step();
        expect_out("R7 awake", O_AWAKE);

        // R3/R4/R5 sweep: one-cycle request during busy, drain window
        for (int ch = 0; ch < 2; ch++) begin
            for (int k = 1; k <= 3; k++) begin
                int dly;
                dly = (ch == 0) ? RD_POST : T_WR;
                if (ch == 0) rd_busy = 1'b1; else wr_busy = 1'b1;
                pd_req = 1'b1;
                step();
                expect_out("R3 busy blocks", O_AWAKE);
                pd_req = 1'b0;
                repeat (k) begin
                    step();
                    expect_out("R3 still busy", O_AWAKE);
                end
                if (ch == 0) begin rd_busy = 1'b0; rd_done = 1'b1; end
                else begin wr_busy = 1'b0; wr_done = 1'b1; end
                step();
                expect_out(ch == 0 ? "R4 done edge" : "R5 done edge", O_AWAKE);
                rd_done = 1'b0; wr_done = 1'b0;
                repeat (dly) begin
                    step();
                    expect_out(ch == 0 ? "R4 draining" : "R5 draining", O_AWAKE);
                end
                step();
                expect_out(ch == 0 ? "R4 entry after drain" : "R5 entry after drain", O_PRE);
                step();
                expect_out("R3 latched request exit", O_NOP);
                step();
                expect_out("R7 awake after latched", O_AWAKE);
            end
        end

        // R8: forced exit with request held; R9: no re-entry until drop
        pd_req = 1'b1;
        step();
        expect_out("R8 entry", O_PRE);
        repeat (MAX_PD - 1) begin
            step();
            expect_out("R8 inside window", O_PRE);
        end
        step();
        expect_out("R8 forced exit", O_NOPRF);
        step();
        expect_out("R8 refresh_due one cycle", O_AWAKE);
        repeat (3) begin
            step();
            expect_out("R9 request ignored", O_AWAKE);
        end
        pd_req = 1'b0;
        step();
        expect_out("R9 drop", O_AWAKE);
        pd_req = 1'b1;
        step();
        expect_out("R9 re-entry", O_PRE);
        pd_req = 1'b0;
        step();
        expect_out("R7 final exit", O_NOP);
        step();
        expect_out("R7 final awake", O_AWAKE);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule